// File: doc/BRIEF.md
# Configurable Watchdog Supervisor with Startup Delay

This block supervises a processor through a single strobe line. While the processor keeps toggling the strobe, the block stays quiet. If the strobe goes quiet for longer than the selected timeout, the block drives an active-low pulse of fixed width. That pulse can feed a reset or an interrupt. After the pulse ends, timing starts again from zero.

A 3-bit select input sets the timing. After reset, and again every time the select value changes, the block first runs a startup phase. During that phase the timeout counter is stopped and no pulse can occur. Codes 0 to 2 give a short startup and codes 3 to 5 a long one. Code 6 waits for the first strobe edge instead of a fixed count. Code 7 switches supervision off. The timeout for codes 0 to 6 is `TO_BASE << code` clock cycles. The pulse width is fixed when the block is built: `LONG_PULSE` picks between `PW_LONG` and `PW_SHORT`. All durations are counted in clock cycles.

The controller has five states. `WD_START` counts the startup delay. `WD_ARM` waits for the first edge. `WD_COUNT` is normal timeout counting. `WD_PULSE` drives the output low. `WD_OFF` means supervision is disabled. The transitions are:
- START→OFF when the code is 7.
- START→ARM when the code is 6.
- START→COUNT when the delay ends.
- ARM→COUNT on a strobe edge.
- COUNT→COUNT, with the counter cleared, on a strobe edge.
- COUNT→PULSE when the timeout expires.
- PULSE→COUNT when the width is reached.
- Any state→START on a select change. This transition has top priority.

Top module: `wdog_supervisor`

## Requirements
- R1: While reset is held, `wdo_n` is 1 and `wd_running` is 0.
- R2: After reset is released with a stable select code, `wd_running` rises exactly `SU_SHORT` cycles later for codes 0–2 and exactly `SU_LONG` cycles later for codes 3–5.
- R3: Once counting starts, if no strobe edge arrives, `wdo_n` falls exactly `TO_BASE << code` cycles after `wd_running` rose.
- R4: Both rising and falling strobe edges clear the timeout counter. The strobe passes through two synchronising flops, so an edge driven before clock k clears the counter at clock k+2. Edges spaced at most one timeout apart keep `wdo_n` high. A spacing of timeout+1 produces a pulse.
- R5: Each pulse keeps `wdo_n` low for `PW_LONG` cycles when `LONG_PULSE`=1, otherwise for `PW_SHORT` cycles. After the pulse, counting resumes from zero, so the next pulse follows a full timeout later.
- R6: A strobe edge that arrives during a pulse neither shortens the pulse nor carries over into the next timeout.
- R7: A change of `wd_sel` restarts the startup phase. The change is synchronised through two flops: `wd_running` is 0 from the third cycle after the change until it rises `SU + 3` cycles after the change. `wdo_n` stays 1 throughout the startup.
- R8: Code 6 holds the startup phase, with no pulse and `wd_running` at 0, until the first strobe edge. `wd_running` then rises three cycles after that edge is driven, and the code-6 timeout applies.
- R9: Code 7 keeps `wdo_n` at 1 and `wd_running` at 0 indefinitely. Changing to another code restarts the startup phase.
- R10: Strobe edges during a fixed startup delay neither shorten nor extend it.
- R11: `wd_running` is 1 only during normal timeout counting. It is 0 during a pulse and returns to 1 in the cycle the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wd_strobe | input | 1 | Processor strobe; any edge counts as a kick |
| wd_sel | input | 3 | Timing/mode select code |
| wdo_n | output | 1 | Active-low watchdog pulse |
| wd_running | output | 1 | High during normal timeout counting |

## Verification
Every fixed-delay code is run with a silent strobe, which separates the startup length, timeout length and pulse width for each code. Strobe trains are applied at exactly the timeout spacing and at one cycle more. These show that both edge directions clear the counter and that the expiry comparison is not off by one. Edges are also injected during startup and during a pulse, which catches an edge that leaks into the wrong phase. Select changes mid-count, the edge-wait code and the disable code cover every way into the startup phase.

// File: rtl/wd_pkg.sv
package wd_pkg;

    typedef enum logic [2:0] {
        WD_START = 3'd0,
        WD_ARM   = 3'd1,
        WD_COUNT = 3'd2,
        WD_PULSE = 3'd3,
        WD_OFF   = 3'd4
    } wd_state_e;

    localparam logic [2:0] SEL_ARM         = 3'd6;
    localparam logic [2:0] SEL_OFF         = 3'd7;
    localparam logic [2:0] SEL_LONG_SU_MIN = 3'd3;

endpackage

// File: rtl/wd_sync.sv
module wd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) stage[0] <= d;
        end else begin : g_next
            always_ff @(posedge clk) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/wd_detect.sv
module wd_detect (
    input  logic       clk,
    input  logic       strobe_s,
    input  logic [2:0] sel_s,
    output logic       strobe_edge,
    output logic       sel_chg,
    output logic [2:0] sel_held
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        strobe_q <= strobe_s;
        sel_held <= sel_s;
    end

    assign strobe_edge = strobe_s ^ strobe_q;
    assign sel_chg     = (sel_s != sel_held);
endmodule

// File: rtl/wd_timing.sv
module wd_timing
    import wd_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int TO_BASE  = 4,
    parameter int SU_SHORT = 10,
    parameter int SU_LONG  = 20
) (
    input  logic [2:0]       sel,
    output logic [CNT_W-1:0] su_cyc,
    output logic [CNT_W-1:0] to_cyc,
    output logic             wait_edge,
    output logic             off
);
    always_comb begin
        off       = (sel == SEL_OFF);
        wait_edge = (sel == SEL_ARM);
        su_cyc    = (sel < SEL_LONG_SU_MIN) ? CNT_W'(SU_SHORT) : CNT_W'(SU_LONG);
        to_cyc    = CNT_W'(TO_BASE) << sel;
    end
endmodule

// File: rtl/wd_fsm.sv
module wd_fsm
    import wd_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int PULSE_CYC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_edge,
    input  logic             sel_chg,
    input  logic [CNT_W-1:0] su_cyc,
    input  logic [CNT_W-1:0] to_cyc,
    input  logic             wait_edge,
    input  logic             off,
    output logic             wdo_n,
    output logic             running
);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] PW_LAST  = CNT_W'(PULSE_CYC - 1);

    wd_state_e        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WD_START;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (sel_chg) begin
            state_n = WD_START;
            cnt_n   = '0;
        end else begin
            unique case (state)
                WD_START: begin
                    if (off) begin
                        state_n = WD_OFF;
                        cnt_n   = '0;
                    end else if (wait_edge) begin
                        state_n = WD_ARM;
                        cnt_n   = '0;
                    end else if (cnt == su_cyc - ONE) begin
                        state_n = WD_COUNT;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
                WD_ARM: begin
                    if (strobe_edge) begin
                        state_n = WD_COUNT;
                        cnt_n   = '0;
                    end
                end
                WD_COUNT: begin
                    if (strobe_edge) begin
                        cnt_n = '0;
                    end else if (cnt == to_cyc - ONE) begin
                        state_n = WD_PULSE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
                WD_PULSE: begin
                    if (cnt == PW_LAST) begin
                        state_n = WD_COUNT;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
                WD_OFF: begin
                    state_n = WD_OFF;
                end
                default: begin
                    state_n = WD_START;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_comb begin
        wdo_n   = (state != WD_PULSE);
        running = (state == WD_COUNT);
    end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
    parameter int TO_BASE    = 4,
    parameter int SU_SHORT   = 10,
    parameter int SU_LONG    = 20,
    parameter int PW_SHORT   = 2,
    parameter int PW_LONG    = 6,
    parameter bit LONG_PULSE = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_strobe,
    input  logic [2:0] wd_sel,
    output logic       wdo_n,
    output logic       wd_running
);
    localparam int PULSE_CYC = LONG_PULSE ? PW_LONG : PW_SHORT;
    localparam int MAX_TO    = TO_BASE << 6;
    localparam int MAX_A     = (SU_LONG > SU_SHORT) ? SU_LONG : SU_SHORT;
    localparam int MAX_B     = (MAX_TO > PULSE_CYC) ? MAX_TO : PULSE_CYC;
    localparam int MAX_CNT   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W     = $clog2(MAX_CNT + 1);

    logic             strobe_s;
    logic [2:0]       sel_s;
    logic             strobe_edge;
    logic             sel_chg;
    logic [2:0]       sel_held;
    logic [CNT_W-1:0] su_cyc;
    logic [CNT_W-1:0] to_cyc;
    logic             wait_edge;
    logic             off;

    wd_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_strobe (
        .clk (clk),
        .d   (wd_strobe),
        .q   (strobe_s)
    );

    wd_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_sel (
        .clk (clk),
        .d   (wd_sel),
        .q   (sel_s)
    );

    wd_detect u_detect (
        .clk         (clk),
        .strobe_s    (strobe_s),
        .sel_s       (sel_s),
        .strobe_edge (strobe_edge),
        .sel_chg     (sel_chg),
        .sel_held    (sel_held)
    );

    wd_timing #(
        .CNT_W    (CNT_W),
        .TO_BASE  (TO_BASE),
        .SU_SHORT (SU_SHORT),
        .SU_LONG  (SU_LONG)
    ) u_timing (
        .sel       (sel_held),
        .su_cyc    (su_cyc),
        .to_cyc    (to_cyc),
        .wait_edge (wait_edge),
        .off       (off)
    );

    wd_fsm #(
        .CNT_W     (CNT_W),
        .PULSE_CYC (PULSE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .strobe_edge (strobe_edge),
        .sel_chg     (sel_chg),
        .su_cyc      (su_cyc),
        .to_cyc      (to_cyc),
        .wait_edge   (wait_edge),
        .off         (off),
        .wdo_n       (wdo_n),
        .running     (wd_running)
    );
endmodule

// File: rtl/wd_checker.sv
module wd_checker #(
    parameter int TO_BASE = 4,
    parameter int PW      = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       wdo_n,
    input logic       running,
    input logic       strobe_edge,
    input logic       sel_chg,
    input logic [2:0] sel_held
);
    int   low_len;
    int   quiet;
    int   exp_to;
    logic in_start;

    assign exp_to = TO_BASE << sel_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_len  <= 0;
            quiet    <= 0;
            in_start <= 1'b1;
        end else begin
            low_len <= wdo_n ? 0 : low_len + 1;
            quiet   <= (!running || strobe_edge) ? 0 : quiet + 1;
            if (sel_chg)      in_start <= 1'b1;
            else if (running) in_start <= 1'b0;
        end
    end

    // R5: a completed pulse lasts exactly the configured width
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
        ($rose(wdo_n) && !$past(sel_chg)) |-> (low_len == PW));

    // R3: a pulse starts only after a full quiet timeout
    a_r3_timeout_len: assert property (@(posedge clk) disable iff (rst)
        $fell(wdo_n) |-> ($past(quiet) == $past(exp_to) - 1));

    // R4: an edge seen while counting prevents a pulse in the next cycle
    a_r4_edge_clears: assert property (@(posedge clk) disable iff (rst)
        (running && strobe_edge && !sel_chg) |=> wdo_n);

    // R7: no pulse in the startup phase
    a_r7_quiet_in_startup: assert property (@(posedge clk) disable iff (rst)
        in_start |-> wdo_n);

    // R9: disable code keeps the outputs idle
    a_r9_disabled: assert property (@(posedge clk) disable iff (rst)
        (sel_held == 3'd7) |-> (wdo_n && !running));

    // R11: running and an active pulse never coincide
    a_r11_run_excl: assert property (@(posedge clk) disable iff (rst)
        running |-> wdo_n);
endmodule

bind wdog_supervisor wd_checker #(
    .TO_BASE (TO_BASE),
    .PW      (PULSE_CYC)
) u_wd_chk (
    .clk         (clk),
    .rst         (rst),
    .wdo_n       (wdo_n),
    .running     (wd_running),
    .strobe_edge (strobe_edge),
    .sel_chg     (sel_chg),
    .sel_held    (sel_held)
);

// File: tb/tb_wdog_supervisor.sv
module tb_wdog_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int TO_BASE  = 4;
    localparam int SU_SHORT = 10;
    localparam int SU_LONG  = 20;
    localparam int PW_LONG  = 6;
    localparam int LIM      = 5000;

    // code, expected startup, expected timeout
    localparam int VEC [6][3] = '{
        '{0, SU_SHORT, TO_BASE << 0},
        '{1, SU_SHORT, TO_BASE << 1},
        '{2, SU_SHORT, TO_BASE << 2},
        '{3, SU_LONG,  TO_BASE << 3},
        '{4, SU_LONG,  TO_BASE << 4},
        '{5, SU_LONG,  TO_BASE << 5}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wd_strobe = 1'b0;
    logic [2:0] wd_sel = 3'd0;
    logic       wdo_n;
    logic       wd_running;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_supervisor #(
        .TO_BASE    (TO_BASE),
        .SU_SHORT   (SU_SHORT),
        .SU_LONG    (SU_LONG),
        .PW_SHORT   (2),
        .PW_LONG    (PW_LONG),
        .LONG_PULSE (1'b1),
        .SYNC_STAGES(2)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .wd_strobe  (wd_strobe),
        .wd_sel     (wd_sel),
        .wdo_n      (wdo_n),
        .wd_running (wd_running)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] code);
        rst = 1'b1;
        wd_sel = code;
        repeat (5) @(negedge clk);
        chk(wdo_n && !wd_running, "R1 reset outputs", {wdo_n, wd_running}, 2'b10);
        rst = 1'b0;
    endtask

    task automatic cnt_run(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wd_running && n < LIM);
    endtask

    task automatic cnt_low(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (wdo_n && n < LIM);
    endtask

    task automatic width_low(output int n);
        n = 1;
        forever begin
            @(negedge clk);
            if (wdo_n || n >= LIM) break;
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit low_seen;
        bit run_seen;

        // table walk over fixed-delay codes
        for (int v = 0; v < 6; v++) begin
            do_reset(3'(VEC[v][0]));
            cnt_run(n);
            chk(n == VEC[v][1], "R2 startup length", n, VEC[v][1]);
            cnt_low(n);
            chk(n == VEC[v][2], "R3 timeout length", n, VEC[v][2]);
            width_low(n);
            chk(n == PW_LONG, "R5 pulse width", n, PW_LONG);
            chk(wd_running == 1'b1, "R11 running after pulse", wd_running, 1);
            cnt_low(n);
            chk(n == VEC[v][2], "R5 restart from zero", n, VEC[v][2]);
        end

        // R4: kicks at exactly the timeout spacing, both edge directions
        do_reset(3'd2);
        cnt_run(n);
        low_seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wd_strobe = ~wd_strobe;
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                if (!wdo_n) low_seen = 1'b1;
            end
        end
        chk(!low_seen, "R4 kicks at timeout spacing", low_seen, 0);
        wd_strobe = ~wd_strobe;
        cnt_low(n);
        chk(n == 16 + 3, "R4 last kick latency", n, 19);
        width_low(n);

        // R4: spacing of timeout+1 must let a pulse through
        low_seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            wd_strobe = ~wd_strobe;
            for (int j = 0; j < 17; j++) begin
                @(negedge clk);
                if (!wdo_n) low_seen = 1'b1;
            end
        end
        chk(low_seen, "R4 kicks one cycle late", low_seen, 1);

        // R6: edge during pulse
        do_reset(3'd0);
        cnt_run(n);
        cnt_low(n);
        wd_strobe = ~wd_strobe;
        width_low(n);
        chk(n == PW_LONG, "R6 pulse not shortened", n, PW_LONG);
        cnt_low(n);
        chk(n == TO_BASE, "R6 edge not carried over", n, TO_BASE);

        // R10: edges during startup
        do_reset(3'd0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n % 2 == 0 && n < 8) wd_strobe = ~wd_strobe;
        end while (!wd_running && n < LIM);
        chk(n == SU_SHORT, "R10 startup unaffected by edges", n, SU_SHORT);
        cnt_low(n);
        chk(n == TO_BASE, "R10 timeout after noisy startup", n, TO_BASE);

        // R7: select change mid-count restarts startup
        do_reset(3'd1);
        cnt_run(n);
        repeat (3) @(negedge clk);
        wd_sel = 3'd4;
        low_seen = 1'b0;
        run_seen = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!wdo_n) low_seen = 1'b1;
            if (n == 3) run_seen = wd_running;
        end while ((n < 3 || !wd_running) && n < LIM);
        chk(!run_seen, "R7 running drops after change", run_seen, 0);
        chk(n == SU_LONG + 3, "R7 restarted startup length", n, SU_LONG + 3);
        chk(!low_seen, "R7 no pulse during startup", low_seen, 0);
        cnt_low(n);
        chk(n == (TO_BASE << 4), "R7 new timeout applies", n, TO_BASE << 4);

        // R8: wait for first edge
        do_reset(3'd6);
        low_seen = 1'b0;
        run_seen = 1'b0;
        repeat (300) begin
            @(negedge clk);
            if (!wdo_n) low_seen = 1'b1;
            if (wd_running) run_seen = 1'b1;
        end
        chk(!low_seen && !run_seen, "R8 idle until edge", {low_seen, run_seen}, 0);
        wd_strobe = ~wd_strobe;
        cnt_run(n);
        chk(n == 3, "R8 counting after first edge", n, 3);
        cnt_low(n);
        chk(n == (TO_BASE << 6), "R8 code 6 timeout", n, TO_BASE << 6);

        // R9: disabled
        do_reset(3'd7);
        low_seen = 1'b0;
        run_seen = 1'b0;
        repeat (600) begin
            @(negedge clk);
            if (!wdo_n) low_seen = 1'b1;
            if (wd_running) run_seen = 1'b1;
        end
        chk(!low_seen && !run_seen, "R9 disabled stays idle", {low_seen, run_seen}, 0);
        wd_sel = 3'd0;
        cnt_run(n);
        chk(n == SU_SHORT + 3, "R9 leaving disable restarts startup", n, SU_SHORT + 3);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule